// File: doc/BRIEF.md
# Command-Complete Register Block

This block is the host side of a sideband command controller on a 32-bit register bus. The single-wire bus itself is not modelled. Software fires a command by setting the go bit in the command word. The block completes the command on the next clock edge and writes a fixed success completion code into both the transmit and the receive data words.

On completion the status word takes the enabled part of the command-done event. The interrupt line is a registered level. It stays high until software clears every status bit by writing ones to them. A fire that arrives while any status bit is still set is refused.

The other words in the decoded range are plain storage. Accesses beyond the range read as zero and are dropped on write.

Top module: `cmdstub_regblk`

## Requirements
- R1: The command word at byte offset 0x08 never stores a write, and a read of it returns 0.
- R2: A write to 0x08 with bit 0 clear changes no word and does not change the interrupt output.
- R3: A write to 0x08 with bit 0 set while the status word (0x1C) is nonzero is refused: no word changes and the interrupt output is unchanged.
- R4: An accepted fire (bit 0 set, status zero) writes 0x40 into the transmit word at 0x20 and the receive word at 0x30 on the clock edge that samples the write.
- R5: On that same edge the status word becomes the enable word (0x18) ANDed with 0x1 (bit 0 is command-done). The interrupt output goes high on that edge if the result is nonzero, and stays low otherwise.
- R6: A write to 0x1C clears the status bits written as 1. The interrupt output falls on the following edge only if the whole status word is then zero.
- R7: A write to any other offset below 0x100 stores the full 32-bit data in the word at offset/4, and a later read returns it.
- R8: A read at byte offset 0x100 or above returns 0. A write there changes no word.
- R9: After reset, every word reads 0, the interrupt output is low and the read data is 0.
- R10: Read data appears on the clock edge that samples the read strobe and holds until the next read. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, high while status is nonzero |

## Verification
Fires are tried with the enable word set and with it clear. This separates a completion that loads the data words without raising the line from one that raises it. Fires are also issued while status is pending, and transmit is preloaded with a distinctive value so that a wrongly accepted fire shows up. Status writes use data of zero, data with bit 0 clear and data with bit 0 set, which checks that only written ones clear and that the line follows the whole word. Random traffic over the whole 12-bit address space mixes stored words, aliased low address bits and out-of-range offsets, and is checked against a bench model of the word file.

// File: rtl/cmdstub_pkg.sv
package cmdstub_pkg;
  localparam int unsigned WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  // Word indices whose behaviour is special
  localparam int unsigned CMD_IDX  = 2;   // 0x08
  localparam int unsigned CTRL_IDX = 6;   // 0x18
  localparam int unsigned STAT_IDX = 7;   // 0x1C
  localparam int unsigned TXD_IDX  = 8;   // 0x20
  localparam int unsigned RXD_IDX  = 12;  // 0x30

  localparam word_t DONE_MASK = word_t'(1);

  // Status value produced by a completed command
  function automatic word_t stat_on_done(word_t enables);
    return enables & DONE_MASK;
  endfunction

  // Write-one-to-clear update
  function automatic word_t w1c(word_t cur, word_t wr);
    return cur & ~wr;
  endfunction
endpackage

// File: rtl/cmdstub_decode.sv
module cmdstub_decode #(
  parameter int unsigned NWORDS = 64,
  parameter int unsigned ADDR_W = 12,
  localparam int unsigned IDX_W = $clog2(NWORDS)
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              go_bit,
  input  logic              stat_pending,
  output logic              addr_hit,
  output logic [IDX_W-1:0]  idx,
  output logic              go_accept,
  output logic              go_refuse,
  output logic              stat_clr,
  output logic              plain_wr
);
  import cmdstub_pkg::*;

  localparam int unsigned LIMIT = NWORDS * 4;

  logic is_cmd, is_stat, wr_hit;

  always_comb begin
    addr_hit = (32'(addr) < LIMIT);
    idx      = IDX_W'(addr >> 2);
    is_cmd   = (32'(idx) == CMD_IDX);
    is_stat  = (32'(idx) == STAT_IDX);
    wr_hit   = wr_en && addr_hit;
  end

  assign go_accept = wr_hit && is_cmd && go_bit && !stat_pending;
  assign go_refuse = wr_hit && is_cmd && go_bit && stat_pending;
  assign stat_clr  = wr_hit && is_stat;
  assign plain_wr  = wr_hit && !is_cmd && !is_stat;
endmodule

// File: rtl/cmdstub_words.sv
module cmdstub_words #(
  parameter int unsigned NWORDS = 64,
  parameter cmdstub_pkg::word_t CODE = 32'h40,
  localparam int unsigned IDX_W = $clog2(NWORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               plain_wr,
  input  logic [IDX_W-1:0]   wr_idx,
  input  cmdstub_pkg::word_t wdata,
  input  logic               stat_clr,
  input  logic               go_accept,
  input  logic               go_refuse,
  output cmdstub_pkg::word_t words_o [NWORDS]
);
  import cmdstub_pkg::*;

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    if (g == CMD_IDX) begin : g_cmd
      assign words_o[g] = '0;
    end else if (g == STAT_IDX) begin : g_stat
      word_t q;
      always_ff @(posedge clk) begin
        if (!rst_n)         q <= '0;
        else if (go_accept) q <= stat_on_done(words_o[CTRL_IDX]);
        else if (stat_clr)  q <= w1c(q, wdata);
      end
      assign words_o[g] = q;
    end else if (g == TXD_IDX || g == RXD_IDX) begin : g_code
      word_t q;
      always_ff @(posedge clk) begin
        if (!rst_n)         q <= '0;
        else if (go_accept) q <= CODE;
        else if (plain_wr && 32'(wr_idx) == g) q <= wdata;
      end
      assign words_o[g] = q;
    end else begin : g_plain
      word_t q;
      always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else if (plain_wr && 32'(wr_idx) == g) q <= wdata;
      end
      assign words_o[g] = q;
    end
  end

  // R4
  fire_loads_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_accept |=> (words_o[TXD_IDX] == CODE && words_o[RXD_IDX] == CODE));

  // R3
  refuse_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_refuse |=> (words_o[STAT_IDX] == $past(words_o[STAT_IDX]) &&
                   words_o[TXD_IDX] == $past(words_o[TXD_IDX]) &&
                   words_o[RXD_IDX] == $past(words_o[RXD_IDX])));
endmodule

// File: rtl/cmdstub_irq.sv
module cmdstub_irq (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go_accept,
  input  logic               stat_clr,
  input  cmdstub_pkg::word_t enables,
  input  cmdstub_pkg::word_t status,
  input  cmdstub_pkg::word_t wdata,
  output logic               irq_o
);
  import cmdstub_pkg::*;

  logic raise_evt, drop_evt;
  assign raise_evt = go_accept && (stat_on_done(enables) != '0);
  assign drop_evt  = stat_clr && (w1c(status, wdata) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)         irq_o <= 1'b0;
    else if (raise_evt) irq_o <= 1'b1;
    else if (drop_evt)  irq_o <= 1'b0;
  end

  // R5
  raise_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raise_evt |=> irq_o);
endmodule

// File: rtl/cmdstub_rdport.sv
module cmdstub_rdport #(
  parameter int unsigned NWORDS = 64,
  localparam int unsigned IDX_W = $clog2(NWORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic               addr_hit,
  input  logic [IDX_W-1:0]   idx,
  input  cmdstub_pkg::word_t words [NWORDS],
  output cmdstub_pkg::word_t rdata_o
);
  import cmdstub_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata_o <= '0;
    else if (rd_en) rdata_o <= addr_hit ? words[idx] : '0;
  end

  // R8
  oob_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !addr_hit) |=> (rdata_o == '0));

  // R1
  cmd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr_hit && 32'(idx) == CMD_IDX) |=> (rdata_o == '0));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata_o));
endmodule

// File: rtl/cmdstub_regblk.sv
module cmdstub_regblk #(
  parameter int unsigned NWORDS = 64,
  parameter int unsigned ADDR_W = 12,
  parameter logic [31:0] CODE = 32'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  import cmdstub_pkg::*;

  localparam int unsigned IDX_W = $clog2(NWORDS);

  word_t            words [NWORDS];
  logic             addr_hit, go_accept, go_refuse, stat_clr, plain_wr;
  logic [IDX_W-1:0] idx;
  logic             stat_pending;

  assign stat_pending = (words[STAT_IDX] != '0);

  cmdstub_decode #(.NWORDS(NWORDS), .ADDR_W(ADDR_W)) u_dec (
    .wr_en(bus_wr), .addr(bus_addr), .go_bit(bus_wdata[0]),
    .stat_pending(stat_pending), .addr_hit(addr_hit), .idx(idx),
    .go_accept(go_accept), .go_refuse(go_refuse),
    .stat_clr(stat_clr), .plain_wr(plain_wr));

  cmdstub_words #(.NWORDS(NWORDS), .CODE(CODE)) u_words (
    .clk(clk), .rst_n(rst_n), .plain_wr(plain_wr), .wr_idx(idx),
    .wdata(bus_wdata), .stat_clr(stat_clr), .go_accept(go_accept),
    .go_refuse(go_refuse), .words_o(words));

  cmdstub_irq u_irq (
    .clk(clk), .rst_n(rst_n), .go_accept(go_accept), .stat_clr(stat_clr),
    .enables(words[CTRL_IDX]), .status(words[STAT_IDX]),
    .wdata(bus_wdata), .irq_o(irq));

  cmdstub_rdport #(.NWORDS(NWORDS)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(bus_rd), .addr_hit(addr_hit),
    .idx(idx), .words(words), .rdata_o(bus_rdata));

  // R6
  irq_tracks_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == (words[STAT_IDX] != '0)));

  // R2
  idle_cmd_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && addr_hit && 32'(idx) == CMD_IDX && !bus_wdata[0]) |=> $stable(irq));
endmodule

// File: tb/cmdstub_regblk_test.sv
module cmdstub_regblk_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m [64];
  logic        m_irq;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  cmdstub_regblk uut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  function automatic logic [31:0] exp_read(logic [11:0] a);
    if (a >= 12'h100) return 32'h0;
    return m[a[7:2]];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_wr(logic [11:0] a, logic [31:0] d);
    int i;
    if (a >= 12'h100) return;
    i = int'(a[7:2]);
    if (i == 2) begin
      if (d[0] && m[7] == 0) begin
        m[8] = 32'h40; m[12] = 32'h40;
        m[7] = m[6] & 32'h1;
        if (m[7] != 0) m_irq = 1'b1;
      end
    end else if (i == 7) begin
      m[7] = m[7] & ~d;
      if (m[7] == 0) m_irq = 1'b0;
    end else m[i] = d;
  endtask

  task automatic do_wr(string tag, logic [11:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
    model_wr(a, d);
    chk(tag, {31'b0, irq}, {31'b0, m_irq});
  endtask

  task automatic do_rd(string tag, logic [11:0] a);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0;
    chk(tag, bus_rdata, exp_read(a));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd_hold;
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) m[i] = '0;
    m_irq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    chk("R9 irq", {31'b0, irq}, 32'h0);
    chk("R9 rdata", bus_rdata, 32'h0);
    do_rd("R9 word0", 12'h000);
    do_rd("R9 status", 12'h01C);
    do_rd("R9 rx", 12'h030);
    // R1/R2 idle command
    do_wr("R2 irq", 12'h008, 32'hFFFF_FFFE);
    do_rd("R1 cmd", 12'h008);
    do_rd("R2 tx", 12'h020);
    do_rd("R2 status", 12'h01C);
    // R4/R5 fire with enable clear
    do_wr("R5 fire-no-enable", 12'h008, 32'h1);
    do_rd("R4 tx", 12'h020);
    do_rd("R4 rx", 12'h030);
    do_rd("R5 status zero", 12'h01C);
    // R5 fire with enable set
    do_wr("R7 tx store", 12'h020, 32'h1234_5678);
    do_rd("R7 tx readback", 12'h020);
    do_wr("R7 enable", 12'h018, 32'hFFFF_FFFF);
    do_wr("R5 fire-enabled", 12'h008, 32'h1);
    chk("R5 irq high", {31'b0, irq}, 32'h1);
    do_rd("R5 status one", 12'h01C);
    do_rd("R4 tx code", 12'h020);
    // R3 refused fire
    do_wr("R7 tx preload", 12'h020, 32'hAAAA_5555);
    do_wr("R3 refused", 12'h008, 32'h1);
    do_rd("R3 tx kept", 12'h020);
    do_rd("R3 status kept", 12'h01C);
    chk("R3 irq kept", {31'b0, irq}, 32'h1);
    // R6 clearing
    do_wr("R6 clear zero", 12'h01C, 32'h0);
    chk("R6 still high", {31'b0, irq}, 32'h1);
    do_wr("R6 clear other bits", 12'h01C, 32'hFFFF_FFFE);
    chk("R6 still high2", {31'b0, irq}, 32'h1);
    do_wr("R6 clear done", 12'h01C, 32'h1);
    chk("R6 low", {31'b0, irq}, 32'h0);
    do_rd("R6 status zero", 12'h01C);
    // R8 out of range
    do_wr("R7 word1", 12'h004, 32'hCAFE_0001);
    do_wr("R8 oob write", 12'h104, 32'hDEAD_BEEF);
    do_rd("R8 oob read", 12'h104);
    do_rd("R8 no alias", 12'h004);
    do_rd("R8 top read", 12'hFFC);
    // R10 low address bits and hold
    do_wr("R7 last word", 12'h0FC, 32'h0BAD_F00D);
    do_rd("R10 low bits", 12'h0FE);
    rd_hold = bus_rdata;
    do_wr("R7 word0", 12'h000, 32'h7777_0000);
    chk("R10 hold", bus_rdata, rd_hold);
    // random traffic
    for (int k = 0; k < 600; k++) begin
      logic [11:0] a;
      int sel;
      sel = int'($urandom % 10);
      if (sel < 2) a = 12'h008;
      else if (sel < 3) a = 12'h01C;
      else if (sel < 4) a = 12'(($urandom % 1024) * 4);
      else a = 12'($urandom % 256);
      if ($urandom % 2 == 0) do_wr("R7 random write", a, $urandom);
      else do_rd("R7 random read", a);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule